// File: doc/BRIEF.md
# Audio Sample Rate Timer with Double-Buffered DAC Register

This block is the sample-output stage of a small audio coprocessor that hangs off an 8-bit CPU bus with a 16-bit address. A programmable 8-bit down-counter, clocked by the coprocessor clock, fires a periodic sample tick that also raises an interrupt. The interrupt handler computes the next sample and stores it by writing to any address in the upper half of the memory map. That store lands in a holding register.

On every tick, the holding register is copied into the output register that drives the DAC. The DAC therefore always plays the sample computed during the previous interval. Output timing is fixed by the counter alone, and how long the handler runs does not affect it, provided the handler finishes within one interval. Every other bus access is decoded to a small shared dual-port RAM. That RAM is mirrored across the whole 64 KiB space by passing only its low address bits.

Top module: `snd_sample_out`

## Requirements
- R1: While rst_ni is low and right after it rises, dac_o is 0x80 (mid-scale), irq_o is 0 and tick_o is 0.
- R2: A cycle with bus_valid_i=1, bus_we_i=1 and bus_addr_i[15]=1 loads bus_wdata_i into the holding register, whatever the other address bits are. dac_o does not change on that write. When several such writes fall in one interval, the last one is kept.
- R3: dac_o changes only on a tick edge. On that edge it takes the holding value from before the edge, so a sample write on the tick edge itself appears at the following tick.
- R4: With period_i = N, the first edge after reset loads the counter, and the first tick happens on the (N+2)th rising edge. After that, ticks come every N+1 clocks. tick_o is high for the one cycle that follows each tick edge.
- R5: A change of period_i takes effect at the next reload, so the interval in progress keeps its old length.
- R6: irq_o is set on each tick edge and stays high until a sample write (R2) or irq_ack_i=1 clears it. If a tick and an acknowledge fall on the same edge, irq_o stays set.
- R7: Every valid access except a sample write asserts ram_cs_o. ram_we_o is asserted for valid writes with bus_addr_i[15]=0. ram_addr_o is bus_addr_i[11:0], which mirrors the 4 KiB RAM across the whole space. With bus_valid_i=0, ram_cs_o and ram_we_o are 0.
- R8: A read (bus_we_i=0) with bus_addr_i[15]=1 goes to the RAM and leaves the holding register unchanged.
- R9: With period_i = 0, a tick happens on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Coprocessor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | CPU address |
| bus_wdata_i | input | 8 | CPU write data |
| period_i | input | 8 | Reload value N; interval is N+1 clocks |
| irq_ack_i | input | 1 | Clears the sample interrupt |
| irq_o | output | 1 | Sample interrupt, level |
| tick_o | output | 1 | One-cycle strobe after each sample transfer |
| dac_o | output | 8 | Sample driving the DAC |
| ram_cs_o | output | 1 | Shared RAM select |
| ram_we_o | output | 1 | Shared RAM write enable |
| ram_addr_o | output | 12 | Shared RAM address |

## Verification
Some rules are checked by the assertions on every cycle. dac_o may change only in a cycle flagged by tick_o. irq_o may rise only with a tick and may fall only after an acknowledge or a sample write. The decode never selects the RAM for a sample write and always selects it for reads. Other behaviour can only be shown by the bench's timed scenarios: the exact interval length and the first-tick position, the one-interval delay of a sample written on a tick edge, a period change waiting for the next reload, and the holding register ignoring reads in the upper half.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned RAM_AW  = 12;
  localparam int unsigned CNT_W   = 8;

  function automatic logic [DATA_W-1:0] mid_scale();
    logic [DATA_W-1:0] v;
    v = '0;
    v[DATA_W-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/snd_bus_dec.sv
module snd_bus_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 12
) (
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              smp_we_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  localparam int unsigned SEL_BIT = ADDR_W - 1;

  logic hi_half;
  assign hi_half  = bus_addr_i[SEL_BIT];
  assign smp_we_o = bus_valid_i & bus_we_i & hi_half;
  assign ram_cs_o = bus_valid_i & ~(bus_we_i & hi_half);
  assign ram_we_o = bus_valid_i & bus_we_i & ~hi_half;

  // mirror: only low bits reach the RAM
  generate
    if (RAM_AW >= ADDR_W) begin : g_full
      assign ram_addr_o = RAM_AW'(bus_addr_i);
    end else begin : g_mirror
      assign ram_addr_o = bus_addr_i[RAM_AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/snd_rate_timer.sv
module snd_rate_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o,
  output logic             tick_q_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick_q;

  assign tick_o   = run_q && (cnt_q == '0);
  assign tick_q_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_o;
      if (!run_q) begin
        // first edge after reset loads the period
        cnt_q <= period_i;
        run_q <= 1'b1;
      end else if (tick_o) begin
        cnt_q <= period_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/snd_sample_buf.sv
module snd_sample_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] dac_o
);
  import snd_pkg::*;

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] dac_q;

  assign dac_o = dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= DATA_W'(mid_scale());
      dac_q  <= DATA_W'(mid_scale());
    end else begin
      if (smp_we_i) hold_q <= wdata_i;
      if (tick_i)   dac_q  <= hold_q;  // old hold, same-edge write waits
    end
  end
endmodule

// File: rtl/snd_irq_ctl.sv
module snd_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (tick_i) irq_q <= 1'b1;  // tick wins over ack
    else if (ack_i)  irq_q <= 1'b0;
  end
endmodule

// File: rtl/snd_sample_out.sv
module snd_sample_out #(
  parameter int unsigned DATA_W = snd_pkg::DATA_W,
  parameter int unsigned ADDR_W = snd_pkg::ADDR_W,
  parameter int unsigned RAM_AW = snd_pkg::RAM_AW,
  parameter int unsigned CNT_W  = snd_pkg::CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic              tick_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o
);
  logic smp_we;
  logic tick;

  snd_bus_dec #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_dec (
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .smp_we_o    (smp_we),
    .ram_cs_o    (ram_cs_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o)
  );

  snd_rate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .tick_o   (tick),
    .tick_q_o (tick_o)
  );

  snd_sample_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_we_i (smp_we),
    .wdata_i  (bus_wdata_i),
    .tick_i   (tick),
    .dac_o    (dac_o)
  );

  snd_irq_ctl u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .ack_i  (smp_we | irq_ack_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/snd_sample_out_chk.sv
module snd_sample_out_chk #(
  parameter int unsigned DATA_W = snd_pkg::DATA_W,
  parameter int unsigned ADDR_W = snd_pkg::ADDR_W,
  parameter int unsigned RAM_AW = snd_pkg::RAM_AW,
  parameter int unsigned CNT_W  = snd_pkg::CNT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [CNT_W-1:0]  period_i,
  input logic              irq_ack_i,
  input logic              irq_o,
  input logic              tick_o,
  input logic [DATA_W-1:0] dac_o,
  input logic              ram_cs_o,
  input logic              ram_we_o,
  input logic [RAM_AW-1:0] ram_addr_o
);
  logic smp_wr;
  assign smp_wr = bus_valid_i && bus_we_i && bus_addr_i[ADDR_W-1];

  assert_dac_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_o != $past(dac_o)) |-> tick_o);

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> tick_o);

  assert_irq_with_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> irq_o);

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_ack_i || smp_wr));

  assert_smp_not_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_wr |-> !ram_cs_o);

  assert_idle_no_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |-> (!ram_cs_o && !ram_we_o));

  assert_read_to_ram_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_we_i) |-> (ram_cs_o && !ram_we_o));
endmodule

bind snd_sample_out snd_sample_out_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/snd_sample_out_tb.sv
`timescale 1ns/1ps
module snd_sample_out_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  period = 8'd5;
  logic        ack = 1'b0;
  logic        irq, tick, ram_cs, ram_we;
  logic [7:0]  dac;
  logic [11:0] ram_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  snd_sample_out u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .period_i(period),
    .irq_ack_i(ack), .irq_o(irq), .tick_o(tick), .dac_o(dac),
    .ram_cs_o(ram_cs), .ram_we_o(ram_we), .ram_addr_o(ram_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // from a negedge, count negedges until tick_o is seen
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 1000);
  endtask

  // drive a write for one edge; returns at the following negedge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    period = 8'd5;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dac == 8'h80, "R1 dac", dac, 8'h80);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac == 8'h80 && irq == 1'b0, "R1 after release", {irq, dac}, 8'h80);
  endtask

  task automatic t_period();
    int n;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_tick(n);
    check(n == 7, "R4 first tick", n, 7);
    check(irq == 1'b1, "R6 irq on tick", irq, 1);
    @(negedge clk);
    check(tick == 1'b0, "R4 tick width", tick, 0);
    wait_tick(n);
    check(n == 5, "R4 interval", n + 1, 6);
    wait_tick(n);
    check(n == 6, "R4 interval2", n, 6);
  endtask

  task automatic t_dac();
    int n;
    bus_write(16'h8000, 8'h11);
    bus_write(16'hBEEF, 8'h3C);
    check(dac == 8'h80, "R2 no direct dac", dac, 8'h80);
    check(irq == 1'b0, "R6 write acks", irq, 0);
    wait_tick(n);
    check(dac == 8'h3C, "R3 dac from hold", dac, 8'h3C);
    repeat (5) @(negedge clk);
    bus_write(16'hFFFF, 8'hA7);
    check(tick == 1'b1, "R3 write lands on tick edge", tick, 1);
    check(dac == 8'h3C, "R3 same-edge write deferred", dac, 8'h3C);
    wait_tick(n);
    check(dac == 8'hA7, "R3 deferred sample", dac, 8'hA7);
  endtask

  task automatic t_irq();
    int n;
    check(irq == 1'b1, "R6 irq set", irq, 1);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R6 irq held", irq, 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(irq == 1'b0, "R6 ack clears", irq, 0);
    wait_tick(n);
    repeat (5) @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(tick == 1'b1 && irq == 1'b1, "R6 tick beats ack", {tick, irq}, 2'b11);
  endtask

  task automatic t_decode();
    int n;
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = 16'h8123; wdata = 8'h5A;
    #1 check(ram_cs == 1'b0 && ram_we == 1'b0, "R7 sample write not ram", {ram_cs, ram_we}, 0);
    @(negedge clk);
    addr = 16'h7ABC;
    #1 check(ram_cs && ram_we && ram_addr == 12'hABC, "R7 ram write", ram_addr, 12'hABC);
    we = 1'b0; addr = 16'hF456; wdata = 8'h11;
    #1 check(ram_cs && !ram_we && ram_addr == 12'h456, "R8 upper read to ram", ram_addr, 12'h456);
    @(negedge clk);
    valid = 1'b0;
    #1 check(!ram_cs && !ram_we, "R7 idle", {ram_cs, ram_we}, 0);
    wait_tick(n);
    check(dac == 8'h5A, "R8 read left hold", dac, 8'h5A);
  endtask

  task automatic t_period_change();
    int n;
    period = 8'd2;
    wait_tick(n);
    check(n == 6, "R5 old interval kept", n, 6);
    wait_tick(n);
    check(n == 3, "R5 new interval", n, 3);
  endtask

  task automatic t_zero();
    int n;
    period = 8'd0;
    wait_tick(n);
    check(n == 3, "R9 old interval", n, 3);
    wait_tick(n);
    check(n == 1, "R9 every clock", n, 1);
    @(negedge clk);
    check(tick == 1'b1, "R9 tick stays high", tick, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_dac();
    t_irq();
    t_decode();
    t_period_change();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule